// File: doc/BRIEF.md
# Zone-Limited 8x8 Forward DCT Engine

This block takes an 8x8 block of unsigned pixel samples and produces its forward two-dimensional discrete cosine transform. It uses the separable form of the transform. One eight-point transform datapath computes all eight outputs of a vector in a single cycle. That datapath first handles each incoming row as soon as the row is complete. After the whole block has arrived, the same datapath processes the columns of the intermediate array.

A zone size N, from 1 to 8, is chosen per block. It limits the work to the low-frequency NxN corner of the coefficient array. In the row pass, only horizontal frequencies below N are stored. The column pass runs only over the first N columns. Only N*N coefficients leave the block, on a valid/ready stream, and a last marker flags the final one.

Intermediate results are kept in a single 8x8 store. Each column-pass result is written back over the column that was just read, so the same store then holds the final coefficients for readout. While the column pass and the readout are in progress, the input is held off.

Top module: `zone_dct2d`

## Requirements
- R1: While reset is held and right after its release, in_ready is 1 and both out_valid and out_last are 0.
- R2: A sample is taken on a rising edge where in_valid and in_ready are both 1. Sample k of a block has row k/8 and column k%8. After the 64th sample is taken, in_ready stays 0 until the handshake of the block's final coefficient. in_valid has no effect during that span.
- R3: zone_size is captured on the handshake of a block's first sample. The values 1 to 8 select N directly, and the values 0 and 9 to 15 select N = 8. Later changes to zone_size have no effect on that block.
- R4: Row pass: y[r][v] = (sum over n of C[v][n]*(s[r][n]-128) + 1024) >> 11, where the shift is arithmetic (floor). Here C[k][n] = round(2048*a_k*cos((2n+1)k*pi/16)), with a_0 = 1/(2*sqrt(2)) and a_k = 1/2 for k >= 1.
- R5: Column pass: X[u][v] = (sum over r of C[u][r]*y[r][v] + 1024) >> 11, computed for u and v below N. Each coefficient is emitted as a 12-bit two's complement value.
- R6: Exactly N*N coefficients are emitted, in the order X[u][v] with the vertical frequency u as the outer index and v as the inner index. out_last is 1 on the final one only.
- R7: out_valid first rises in the cycle after the (N+1)-th rising edge that follows the edge taking the 64th sample. That span is one cycle for the last row plus one cycle per column.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_coef and out_last keep their values.
- R9: In the cycle after the final coefficient's handshake, in_ready is 1 and out_valid is 0. The next block's coefficients depend on that block's samples only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | SAMPLE_W | Unsigned pixel sample, row-major |
| zone_size | input | 4 | Requested zone N, captured with a block's first sample |
| out_valid | output | 1 | Coefficient present |
| out_ready | input | 1 | Consumer takes the coefficient |
| out_coef | output | COEF_W | Signed transform coefficient |
| out_last | output | 1 | Final coefficient of the zone |

## Verification
The bench runs several pixel patterns through the block:
- A linear ramp and a pseudo-random fill spread energy across many coefficients, so they expose sign, rounding and index-order mistakes.
- Flat blocks of all zeros and all 255 should leave only the DC term, and they drive the accumulators to their extremes.
- A checkerboard puts its energy in the highest frequency. Under a 1x1 zone it shows whether that energy is correctly kept out of the DC term.
- A pattern that varies only by row separates the vertical pass from the horizontal one.

Zones of 1, 3, 5 and 8 and the out-of-range codes are tried, together with gaps in the input, stalls on the output and a zone change in the middle of a block. These runs show whether the zone is captured at the right moment and whether the latency follows N.

// File: rtl/zdct_pkg.sv
package zdct_pkg;

   localparam int NPT     = 8;
   localparam int IDX_W   = $clog2(NPT);
   localparam int ZONE_W  = IDX_W + 1;
   localparam int CONST_W = 12;
   localparam int FRAC_W  = 11;

   typedef enum logic [1:0] {
      ST_LOAD,
      ST_COLS,
      ST_EMIT
   } zdct_state_e;

   // Cosine weight for output index k and input index n, scaled by 2^FRAC_W.
   function automatic logic signed [CONST_W-1:0] cos_const(input int k, input int n);
      int  m;
      int  mag;
      logic neg;
      m   = ((2 * n + 1) * k) % 32;
      neg = 1'b0;
      if (m > 16) m = 32 - m;
      if (m > 8) begin
         m   = 16 - m;
         neg = 1'b1;
      end
      case (m)
         0:       mag = 1024;
         1:       mag = 1004;
         2:       mag = 946;
         3:       mag = 851;
         4:       mag = 724;
         5:       mag = 569;
         6:       mag = 392;
         7:       mag = 200;
         default: mag = 0;
      endcase
      if (k == 0) mag = 724;
      return CONST_W'(neg ? -mag : mag);
   endfunction

endpackage

// File: rtl/zdct_1d.sv
module zdct_1d
   import zdct_pkg::*;
#(
   parameter int IN_W  = 12,
   parameter int OUT_W = 12
) (
   input  logic signed [IN_W-1:0]  vec_i   [NPT],
   input  logic        [NPT-1:0]   lane_en_i,
   output logic signed [OUT_W-1:0] res_o   [NPT]
);

   localparam int ACC_W = IN_W + CONST_W + IDX_W + 1;
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);

   if (ACC_W > 63) begin : g_bad_acc
      $error("zdct_1d: accumulator too wide");
   end

   for (genvar k = 0; k < NPT; k++) begin : g_lane
      logic signed [ACC_W-1:0] prod [NPT];
      logic signed [ACC_W-1:0] acc;
      logic signed [ACC_W-1:0] rnd;

      for (genvar n = 0; n < NPT; n++) begin : g_tap
         localparam logic signed [CONST_W-1:0] WK = cos_const(k, n);
         assign prod[n] = lane_en_i[k] ? (ACC_W'(vec_i[n]) * ACC_W'(WK)) : '0;
      end

      always_comb begin
         acc = '0;
         for (int n = 0; n < NPT; n++) begin
            acc = acc + prod[n];
         end
         rnd = acc + HALF;
      end

      assign res_o[k] = OUT_W'(rnd >>> FRAC_W);
   end

endmodule

// File: rtl/zdct_tbuf.sv
module zdct_tbuf
   import zdct_pkg::*;
#(
   parameter int W = 12
) (
   input  logic                clk,
   input  logic                row_we_i,
   input  logic [IDX_W-1:0]    row_sel_i,
   input  logic [NPT-1:0]      lane_en_i,
   input  logic signed [W-1:0] row_din_i [NPT],
   input  logic                col_we_i,
   input  logic [IDX_W-1:0]    col_sel_i,
   input  logic signed [W-1:0] col_din_i [NPT],
   output logic signed [W-1:0] col_dout_o [NPT],
   input  logic [IDX_W-1:0]    rd_row_i,
   input  logic [IDX_W-1:0]    rd_col_i,
   output logic signed [W-1:0] rd_dout_o
);

   logic signed [W-1:0] mem [NPT][NPT];

   // Row writes land across a row; column writes overwrite the column just read.
   always_ff @(posedge clk) begin
      for (int r = 0; r < NPT; r++) begin
         for (int c = 0; c < NPT; c++) begin
            if (row_we_i && row_sel_i == IDX_W'(r) && lane_en_i[c]) begin
               mem[r][c] <= row_din_i[c];
            end else if (col_we_i && col_sel_i == IDX_W'(c) && lane_en_i[r]) begin
               mem[r][c] <= col_din_i[r];
            end
         end
      end
   end

   for (genvar r = 0; r < NPT; r++) begin : g_colrd
      assign col_dout_o[r] = mem[r][col_sel_i];
   end

   assign rd_dout_o = mem[rd_row_i][rd_col_i];

endmodule

// File: rtl/zdct_ctrl.sv
module zdct_ctrl
   import zdct_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   output logic              in_ready_o,
   input  logic [ZONE_W-1:0] zone_i,
   output logic              accept_o,
   output logic              row_end_o,
   output logic              row_we_o,
   output logic [IDX_W-1:0]  row_sel_o,
   output logic              col_we_o,
   output logic [IDX_W-1:0]  col_sel_o,
   output logic [NPT-1:0]    lane_en_o,
   input  logic              out_ready_i,
   output logic              out_valid_o,
   output logic              out_last_o,
   output logic [IDX_W-1:0]  rd_row_o,
   output logic [IDX_W-1:0]  rd_col_o
);

   localparam int CNT_W = 2 * IDX_W + 1;
   localparam int BLK   = NPT * NPT;

   zdct_state_e       state_q;
   logic [CNT_W-1:0]  smp_cnt_q;
   logic [ZONE_W-1:0] zone_q;
   logic [ZONE_W-1:0] zone_eff;
   logic [IDX_W-1:0]  zlast;
   logic              row_pend_q;
   logic [IDX_W-1:0]  row_idx_q;
   logic [IDX_W-1:0]  col_q;
   logic [IDX_W-1:0]  er_q;
   logic [IDX_W-1:0]  ec_q;
   logic              emit_end;

   assign zone_eff   = (zone_i == '0 || zone_i > ZONE_W'(NPT)) ? ZONE_W'(NPT) : zone_i;
   assign zlast      = IDX_W'(zone_q - ZONE_W'(1));
   assign in_ready_o = (state_q == ST_LOAD) && (smp_cnt_q != CNT_W'(BLK));
   assign accept_o   = in_valid_i && in_ready_o;
   assign row_end_o  = accept_o && (smp_cnt_q[IDX_W-1:0] == '1);
   assign row_we_o   = row_pend_q;
   assign row_sel_o  = row_idx_q;
   assign col_we_o   = (state_q == ST_COLS);
   assign col_sel_o  = col_q;
   assign out_valid_o = (state_q == ST_EMIT);
   assign emit_end   = (er_q == zlast) && (ec_q == zlast);
   assign out_last_o = out_valid_o && emit_end;
   assign rd_row_o   = er_q;
   assign rd_col_o   = ec_q;

   for (genvar k = 0; k < NPT; k++) begin : g_lane_en
      assign lane_en_o[k] = (ZONE_W'(k) < zone_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_LOAD;
         smp_cnt_q  <= '0;
         zone_q     <= ZONE_W'(NPT);
         row_pend_q <= 1'b0;
         row_idx_q  <= '0;
         col_q      <= '0;
         er_q       <= '0;
         ec_q       <= '0;
      end else begin
         row_pend_q <= row_end_o;
         if (row_end_o) row_idx_q <= smp_cnt_q[CNT_W-2:IDX_W];
         if (accept_o) begin
            smp_cnt_q <= smp_cnt_q + CNT_W'(1);
            if (smp_cnt_q == '0) zone_q <= zone_eff;
         end
         case (state_q)
            ST_LOAD: begin
               if (row_pend_q && row_idx_q == '1) begin
                  state_q <= ST_COLS;
                  col_q   <= '0;
               end
            end
            ST_COLS: begin
               if (col_q == zlast) begin
                  state_q <= ST_EMIT;
                  er_q    <= '0;
                  ec_q    <= '0;
               end else begin
                  col_q <= col_q + IDX_W'(1);
               end
            end
            ST_EMIT: begin
               if (out_ready_i) begin
                  if (emit_end) begin
                     state_q   <= ST_LOAD;
                     smp_cnt_q <= '0;
                  end else if (ec_q == zlast) begin
                     ec_q <= '0;
                     er_q <= er_q + IDX_W'(1);
                  end else begin
                     ec_q <= ec_q + IDX_W'(1);
                  end
               end
            end
            default: state_q <= ST_LOAD;
         endcase
      end
   end

   // R2: no sample may enter while coefficients are being delivered
   assert_ready_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> !in_ready_o);

   // R3: the captured zone is always a legal size
   assert_zone_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (zone_q != '0) && (zone_q <= ZONE_W'(NPT)));

   // R3: outside sample loading the zone cannot move
   assert_zone_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_LOAD) |=> $stable(zone_q));

   // R7: column pass visits only columns inside the zone
   assert_col_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      col_we_o |-> (ZONE_W'(col_sel_o) < zone_q));

   // R4: a row write and a column write never share a cycle
   assert_wr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(row_we_o && col_we_o));

   // R6: the last marker only rides on a valid coefficient
   assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last_o |-> out_valid_o);

endmodule

// File: rtl/zone_dct2d.sv
module zone_dct2d
   import zdct_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int COEF_W   = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [SAMPLE_W-1:0]      in_sample,
   input  logic [ZONE_W-1:0]        zone_size,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic signed [COEF_W-1:0] out_coef,
   output logic                     out_last
);

   if (COEF_W < CONST_W) begin : g_bad_coef
      $error("zone_dct2d: COEF_W narrower than the coefficient range");
   end
   if (SAMPLE_W < 2 || SAMPLE_W >= COEF_W) begin : g_bad_samp
      $error("zone_dct2d: SAMPLE_W out of range");
   end

   logic                     accept;
   logic                     row_end;
   logic                     row_we;
   logic [IDX_W-1:0]         row_sel;
   logic                     col_we;
   logic [IDX_W-1:0]         col_sel;
   logic [NPT-1:0]           lane_en;
   logic [IDX_W-1:0]         rd_row;
   logic [IDX_W-1:0]         rd_col;
   logic signed [COEF_W-1:0] shifted;
   logic signed [COEF_W-1:0] sh_q   [NPT-1];
   logic signed [COEF_W-1:0] hold_q [NPT];
   logic signed [COEF_W-1:0] dct_in  [NPT];
   logic signed [COEF_W-1:0] dct_out [NPT];
   logic signed [COEF_W-1:0] col_dout [NPT];

   // Offset removal: flipping the top bit of an unsigned sample subtracts half scale.
   assign shifted = COEF_W'($signed({~in_sample[SAMPLE_W-1], in_sample[SAMPLE_W-2:0]}));

   always_ff @(posedge clk) begin
      if (accept) begin
         for (int j = 0; j < NPT - 2; j++) begin
            sh_q[j] <= sh_q[j+1];
         end
         sh_q[NPT-2] <= shifted;
      end
      if (row_end) begin
         for (int j = 0; j < NPT - 1; j++) begin
            hold_q[j] <= sh_q[j];
         end
         hold_q[NPT-1] <= shifted;
      end
   end

   for (genvar n = 0; n < NPT; n++) begin : g_mux
      assign dct_in[n] = col_we ? col_dout[n] : hold_q[n];
   end

   zdct_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (in_valid),
      .in_ready_o  (in_ready),
      .zone_i      (zone_size),
      .accept_o    (accept),
      .row_end_o   (row_end),
      .row_we_o    (row_we),
      .row_sel_o   (row_sel),
      .col_we_o    (col_we),
      .col_sel_o   (col_sel),
      .lane_en_o   (lane_en),
      .out_ready_i (out_ready),
      .out_valid_o (out_valid),
      .out_last_o  (out_last),
      .rd_row_o    (rd_row),
      .rd_col_o    (rd_col)
   );

   zdct_1d #(
      .IN_W  (COEF_W),
      .OUT_W (COEF_W)
   ) u_xform (
      .vec_i     (dct_in),
      .lane_en_i (lane_en),
      .res_o     (dct_out)
   );

   zdct_tbuf #(
      .W (COEF_W)
   ) u_tbuf (
      .clk        (clk),
      .row_we_i   (row_we),
      .row_sel_i  (row_sel),
      .lane_en_i  (lane_en),
      .row_din_i  (dct_out),
      .col_we_i   (col_we),
      .col_sel_i  (col_sel),
      .col_din_i  (dct_out),
      .col_dout_o (col_dout),
      .rd_row_i   (rd_row),
      .rd_col_i   (rd_col),
      .rd_dout_o  (out_coef)
   );

   // R8: a stalled coefficient stays put
   assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_coef) && $stable(out_last)));

endmodule

// File: tb/zone_dct2d_tb.sv
module zone_dct2d_tb;

   logic              clk;
   logic              rst_n;
   logic              in_valid;
   logic              in_ready;
   logic [7:0]        in_sample;
   logic [3:0]        zone_size;
   logic              out_valid;
   logic              out_ready;
   logic signed [11:0] out_coef;
   logic              out_last;

   int checks;
   int fails;
   int samp [64];
   int expv [8][8];

   zone_dct2d u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_sample (in_sample),
      .zone_size (zone_size),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_coef  (out_coef),
      .out_last  (out_last)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int wcos(input int k, input int n);
      real a;
      real v;
      a = (k == 0) ? 1.0 / (2.0 * $sqrt(2.0)) : 0.5;
      v = 2048.0 * a * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0);
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
   endfunction

   function automatic int pattern(input int kind, input int i);
      case (kind)
         0: return (i * 4) % 256;
         1: return 255;
         2: return (((i / 8) + (i % 8)) % 2) * 255;
         3: return (i * 37 + 11) % 256;
         4: return 0;
         5: return (i * i * 7 + 3) % 256;
         default: return (i / 8) * 32;
      endcase
   endfunction

   task automatic build_expected();
      int y [8][8];
      int acc;
      for (int r = 0; r < 8; r++) begin
         for (int v = 0; v < 8; v++) begin
            acc = 0;
            for (int n = 0; n < 8; n++) acc += wcos(v, n) * (samp[r*8+n] - 128);
            y[r][v] = (acc + 1024) >>> 11;
         end
      end
      for (int u = 0; u < 8; u++) begin
         for (int v = 0; v < 8; v++) begin
            acc = 0;
            for (int r = 0; r < 8; r++) acc += wcos(u, r) * y[r][v];
            expv[u][v] = (acc + 1024) >>> 11;
         end
      end
   endtask

   // One block: drive 64 samples, measure latency, collect and compare the zone.
   task automatic run_block(input string name, input int zdrv, input int zalt, input int zeff,
                            input int kind, input bit gaps, input bit stall);
      int lat;
      int idx;
      int cyc;
      int held_val;
      bit held;
      bit quiet;
      for (int i = 0; i < 64; i++) samp[i] = pattern(kind, i);
      build_expected();
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (gaps && (i % 5 == 2)) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         in_valid  = 1'b1;
         in_sample = samp[i][7:0];
         zone_size = (i == 0) ? zdrv[3:0] : zalt[3:0];
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      // R2 and R7: hold in_valid high with junk; in_ready must stay low
      lat   = 0;
      quiet = 1'b1;
      do begin
         @(negedge clk);
         lat++;
         in_valid  = 1'b1;
         in_sample = 8'hA5;
         zone_size = 4'd2;
         if (in_ready) quiet = 1'b0;
      end while (!out_valid && lat < 40);
      in_valid = 1'b0;
      chk("R2", {name, " in_ready low after full block"}, int'(quiet), 1);
      chk("R7", {name, " latency to first coefficient"}, lat - 1, zeff + 1);
      idx  = 0;
      cyc  = 0;
      held = 1'b0;
      while (idx < zeff * zeff && cyc < 400) begin
         if (held && out_valid) chk("R8", {name, " stalled value held"}, int'(out_coef), held_val);
         held = 1'b0;
         out_ready = stall ? (cyc % 3 == 2) : 1'b1;
         if (out_valid) begin
            if (in_ready) chk("R2", {name, " in_ready during output"}, int'(in_ready), 0);
            if (out_ready) begin
               chk("R5", {name, " coefficient value"}, int'(out_coef), expv[idx / zeff][idx % zeff]);
               chk("R6", {name, " last marker"}, int'(out_last), int'(idx == zeff * zeff - 1));
               idx++;
            end else begin
               held     = 1'b1;
               held_val = int'(out_coef);
            end
         end
         cyc++;
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk("R6", {name, " coefficient count"}, idx, zeff * zeff);
      chk("R9", {name, " in_ready after last"}, int'(in_ready), 1);
      chk("R6", {name, " no extra coefficient"}, int'(out_valid), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog run did not finish actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      checks    = 0;
      fails     = 0;
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_sample = 8'd0;
      zone_size = 4'd8;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "in_ready in reset", int'(in_ready), 1);
      chk("R1", "out_valid in reset", int'(out_valid), 0);
      chk("R1", "out_last in reset", int'(out_last), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "in_ready after reset", int'(in_ready), 1);
      chk("R1", "out_valid after reset", int'(out_valid), 0);

      // R4 R5 R6 R7: full zone, ramp
      run_block("ramp_z8", 8, 8, 8, 0, 1'b0, 1'b0);
      // R4 R5: flat maximum, DC only
      run_block("flat255_z8", 8, 8, 8, 1, 1'b0, 1'b0);
      // R5 R7: checkerboard under a 1x1 zone
      run_block("checker_z1", 1, 1, 1, 2, 1'b0, 1'b0);
      // R3 R8: zone changes mid-block, gaps and stalls
      run_block("mixed_z3_late7", 3, 7, 3, 3, 1'b1, 1'b1);
      // R3: zone code 0 selects 8
      run_block("zero_code", 0, 5, 8, 4, 1'b0, 1'b1);
      // R3: zone code 12 selects 8
      run_block("code12", 12, 2, 8, 5, 1'b0, 1'b0);
      // R9: back-to-back block with another zone
      run_block("rows_z5", 5, 5, 5, 6, 1'b1, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule